// File: doc/BRIEF.md
# Eight-Region Address Protection and Translation Unit

This unit checks and optionally relocates every memory access of a small processor core. The 32-bit address space is cut into eight equal regions of 512 MB, and the region is chosen by the three most significant address bits. Two independent tables of eight entries exist: one serves instruction fetches, the other serves loads and stores. Each entry carries a 4-bit attribute code and a 3-bit physical region number.

For each lookup the unit returns, one cycle later, the physical address, the fixed page size, the read/write/execute rights and the cache policy that the attribute code decodes to. When the access kind is not permitted by those rights it also returns a fault flag with a cause code. Software rewrites one entry at a time through a write port. The physical region number is only replaced while the translation-enable input is high, so a protection-only configuration keeps the identity mapping it had after reset.

Top module: `region_guard`

## Requirements
- R1: The region index is `req_vaddr[31:29]`. `rsp_paddr` is the selected entry's 3-bit physical region number in bits 31:29, followed by `req_vaddr[28:0]` unchanged.
- R2: Attribute codes decode to `rsp_rwx` (bit 2 read, bit 1 write, bit 0 execute) and `rsp_cache` (0 bypass, 1 write-through, 2 write-back, 3 isolate) as follows. Code 0 gives rw-/write-through. Code 1 gives rwx/write-through. Code 2 gives rwx/bypass. Code 3 gives --x/write-back. Codes 4 and 5 give rwx/write-back. Code 14 gives rw-/isolate.
- R3: Every other attribute code (6 to 13 and 15) grants no rights (`rsp_rwx` = 0) and reports cache policy 0.
- R4: A lookup whose kind lacks the matching right sets `rsp_fault`. The `rsp_cause` value is 1 for a read without read right, 2 for a write without write right and 3 for a fetch without execute right. A permitted lookup gives `rsp_fault` = 0 and `rsp_cause` = 0.
- R5: After reset, entry i of both tables has physical region number i and attribute code 2, so every address maps to itself with full rights and bypass. `rsp_valid` and `rsp_fault` are 0.
- R6: A write (`wr_en`) loads `wr_attr` into the entry `wr_region` of the table chosen by `wr_instr`. It loads `wr_base` into the same entry only when `xlat_en` is 1; otherwise the physical region number is kept.
- R7: `rsp_page_size` is always 0x2000_0000 (512 MB).
- R8: `req_kind` 2 (fetch) uses the instruction table. Kinds 0 (read) and 1 (write) use the data table. Kind 3 behaves exactly as a read. `wr_instr` = 1 writes the instruction table and 0 writes the data table; a write to one table leaves the other unchanged.
- R9: Results appear one clock after `req_valid`, with `rsp_valid` high for exactly that cycle. A lookup in the same cycle as a write to its entry sees the old entry, and the next lookup sees the new one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| xlat_en | input | 1 | Translation enable: writes may change the physical region number |
| req_valid | input | 1 | Lookup request |
| req_kind | input | 2 | 0 read, 1 write, 2 fetch, 3 read |
| req_vaddr | input | 32 | Virtual address of the lookup |
| wr_en | input | 1 | Entry write strobe |
| wr_instr | input | 1 | 1 selects the instruction table, 0 the data table |
| wr_region | input | 3 | Entry index to write |
| wr_base | input | 3 | New physical region number |
| wr_attr | input | 4 | New attribute code |
| rsp_valid | output | 1 | Result valid |
| rsp_paddr | output | 32 | Physical address |
| rsp_page_size | output | 32 | Region size in bytes |
| rsp_rwx | output | 3 | Rights: read, write, execute |
| rsp_cache | output | 2 | Cache policy |
| rsp_fault | output | 1 | Access not permitted |
| rsp_cause | output | 2 | 0 none, 1 load, 2 store, 3 fetch prohibited |

## Verification
The bench builds the unit with its default parameters: 32-bit addresses, a 3-bit region index and 4-bit attribute codes. These values keep the whole configuration space small enough for directed tests to cover it completely. All eight regions of both tables are visited, and all sixteen attribute codes are tried with reads, writes and fetches. The relocation case checks that translation remaps the upper address bits without touching the offset, and the write-collision case checks that a lookup and a write to the same entry in one cycle behave as R9 requires.

// File: rtl/rgn_pkg.sv
`timescale 1ns/1ps
package rgn_pkg;
  typedef enum logic [1:0] {
    KIND_READ  = 2'd0,
    KIND_WRITE = 2'd1,
    KIND_FETCH = 2'd2,
    KIND_RSVD  = 2'd3
  } acc_kind_e;

  typedef enum logic [1:0] {
    CAUSE_NONE  = 2'd0,
    CAUSE_LOAD  = 2'd1,
    CAUSE_STORE = 2'd2,
    CAUSE_FETCH = 2'd3
  } fault_cause_e;

  typedef enum logic [1:0] {
    POL_BYPASS  = 2'd0,
    POL_WTHRU   = 2'd1,
    POL_WBACK   = 2'd2,
    POL_ISOLATE = 2'd3
  } cache_pol_e;

  typedef struct packed {
    logic       rd;
    logic       wr;
    logic       ex;
    cache_pol_e pol;
  } attr_dec_t;
endpackage

// File: rtl/rgn_attr_decode.sv
`timescale 1ns/1ps
module rgn_attr_decode
  import rgn_pkg::*;
#(
  parameter int ATTR_W = 4
) (
  input  logic [ATTR_W-1:0] code,
  output attr_dec_t         dec
);
  always_comb begin
    dec = '{rd: 1'b0, wr: 1'b0, ex: 1'b0, pol: POL_BYPASS};
    case (int'(code))
      0:    dec = '{rd: 1'b1, wr: 1'b1, ex: 1'b0, pol: POL_WTHRU};
      1:    dec = '{rd: 1'b1, wr: 1'b1, ex: 1'b1, pol: POL_WTHRU};
      2:    dec = '{rd: 1'b1, wr: 1'b1, ex: 1'b1, pol: POL_BYPASS};
      3:    dec = '{rd: 1'b0, wr: 1'b0, ex: 1'b1, pol: POL_WBACK};
      4, 5: dec = '{rd: 1'b1, wr: 1'b1, ex: 1'b1, pol: POL_WBACK};
      14:   dec = '{rd: 1'b1, wr: 1'b1, ex: 1'b0, pol: POL_ISOLATE};
      default: ;
    endcase
  end

  always_comb begin
    // R3
    undef_code_chk: assert (!(dec.rd || dec.wr || dec.ex) || (int'(code) <= 5) || (int'(code) == 14));
    // R2
    exec_only_chk: assert ((int'(code) != 3) || (!dec.rd && !dec.wr && dec.ex));
  end
endmodule

// File: rtl/rgn_table.sv
`timescale 1ns/1ps
module rgn_table #(
  parameter int IDX_W      = 3,
  parameter int ATTR_W     = 4,
  parameter int RESET_ATTR = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              xlat_en,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [IDX_W-1:0]  wr_base,
  input  logic [ATTR_W-1:0] wr_attr,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [IDX_W-1:0]  rd_base,
  output logic [ATTR_W-1:0] rd_attr
);
  localparam int NREG = 1 << IDX_W;

  logic [NREG-1:0][IDX_W-1:0]  base_q;
  logic [NREG-1:0][ATTR_W-1:0] attr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) begin
        base_q[i] <= IDX_W'(i);
        attr_q[i] <= ATTR_W'(RESET_ATTR);
      end
    end else if (wr_en) begin
      attr_q[wr_idx] <= wr_attr;
      if (xlat_en) base_q[wr_idx] <= wr_base;
    end
  end

  assign rd_base = base_q[rd_idx];
  assign rd_attr = attr_q[rd_idx];

  // R6
  base_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !xlat_en) |=> $stable(base_q));
  // R6
  attr_load_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> attr_q[$past(wr_idx)] == $past(wr_attr));
endmodule

// File: rtl/region_guard.sv
`timescale 1ns/1ps
module region_guard
  import rgn_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int IDX_W      = 3,
  parameter int ATTR_W     = 4,
  parameter int RESET_ATTR = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              xlat_en,
  input  logic              req_valid,
  input  logic [1:0]        req_kind,
  input  logic [ADDR_W-1:0] req_vaddr,
  input  logic              wr_en,
  input  logic              wr_instr,
  input  logic [IDX_W-1:0]  wr_region,
  input  logic [IDX_W-1:0]  wr_base,
  input  logic [ATTR_W-1:0] wr_attr,
  output logic              rsp_valid,
  output logic [ADDR_W-1:0] rsp_paddr,
  output logic [ADDR_W-1:0] rsp_page_size,
  output logic [2:0]        rsp_rwx,
  output logic [1:0]        rsp_cache,
  output logic              rsp_fault,
  output logic [1:0]        rsp_cause
);
  localparam int OFS_W  = ADDR_W - IDX_W;
  localparam int NTABLE = 2;   // 0 data, 1 instruction

  logic [IDX_W-1:0]  look_idx;
  logic [IDX_W-1:0]  tbl_base [NTABLE];
  logic [ATTR_W-1:0] tbl_attr [NTABLE];

  assign look_idx = req_vaddr[ADDR_W-1 -: IDX_W];

  for (genvar t = 0; t < NTABLE; t++) begin : g_tbl
    logic sel_wr;
    assign sel_wr = wr_en && (wr_instr == (t == 1));
    rgn_table #(
      .IDX_W(IDX_W), .ATTR_W(ATTR_W), .RESET_ATTR(RESET_ATTR)
    ) u_tbl (
      .clk(clk), .rst(rst), .xlat_en(xlat_en),
      .wr_en(sel_wr), .wr_idx(wr_region), .wr_base(wr_base), .wr_attr(wr_attr),
      .rd_idx(look_idx), .rd_base(tbl_base[t]), .rd_attr(tbl_attr[t])
    );
  end

  acc_kind_e         kind;
  logic              use_instr;
  logic [IDX_W-1:0]  sel_base;
  logic [ATTR_W-1:0] sel_attr;
  attr_dec_t         dec;
  logic              allow;
  fault_cause_e      deny_cause;

  assign kind      = acc_kind_e'(req_kind);
  assign use_instr = (kind == KIND_FETCH);
  assign sel_base  = use_instr ? tbl_base[1] : tbl_base[0];
  assign sel_attr  = use_instr ? tbl_attr[1] : tbl_attr[0];

  rgn_attr_decode #(.ATTR_W(ATTR_W)) u_dec (.code(sel_attr), .dec(dec));

  always_comb begin
    case (kind)
      KIND_WRITE: begin allow = dec.wr; deny_cause = CAUSE_STORE; end
      KIND_FETCH: begin allow = dec.ex; deny_cause = CAUSE_FETCH; end
      default:    begin allow = dec.rd; deny_cause = CAUSE_LOAD;  end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_paddr <= '0;
      rsp_rwx   <= '0;
      rsp_cache <= '0;
      rsp_fault <= 1'b0;
      rsp_cause <= CAUSE_NONE;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        rsp_paddr <= {sel_base, req_vaddr[OFS_W-1:0]};
        rsp_rwx   <= {dec.rd, dec.wr, dec.ex};
        rsp_cache <= dec.pol;
        rsp_fault <= !allow;
        rsp_cause <= allow ? CAUSE_NONE : deny_cause;
      end else begin
        rsp_fault <= 1'b0;
        rsp_cause <= CAUSE_NONE;
      end
    end
  end

  assign rsp_page_size = ADDR_W'(1) << OFS_W;

  // R9
  lat_on_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);
  // R9
  lat_off_chk: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !rsp_valid);
  // R4
  fault_cause_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_fault |-> rsp_cause != CAUSE_NONE);
  // R4
  clean_cause_chk: assert property (@(posedge clk) disable iff (rst)
    !rsp_fault |-> rsp_cause == CAUSE_NONE);
  // R4
  fetch_cause_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_kind == 2'd2) |=> (!rsp_fault || rsp_cause == CAUSE_FETCH));
  // R4
  load_rights_chk: assert property (@(posedge clk) disable iff (rst)
    (rsp_fault && rsp_cause == CAUSE_LOAD) |-> !rsp_rwx[2]);
  // R1
  offset_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_paddr[OFS_W-1:0] == $past(req_vaddr[OFS_W-1:0]));
endmodule

// File: tb/sim_region_guard.sv
`timescale 1ns/1ps
module sim_region_guard;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        xlat_en = 1'b0;
  logic        req_valid = 1'b0;
  logic [1:0]  req_kind = 2'd0;
  logic [31:0] req_vaddr = '0;
  logic        wr_en = 1'b0;
  logic        wr_instr = 1'b0;
  logic [2:0]  wr_region = '0;
  logic [2:0]  wr_base = '0;
  logic [3:0]  wr_attr = '0;
  logic        rsp_valid;
  logic [31:0] rsp_paddr;
  logic [31:0] rsp_page_size;
  logic [2:0]  rsp_rwx;
  logic [1:0]  rsp_cache;
  logic        rsp_fault;
  logic [1:0]  rsp_cause;

  int n_chk = 0;
  int n_bad = 0;
  logic [2:0] mb [2][8];
  logic [3:0] ma [2][8];

  always #10 clk = ~clk;

  region_guard u0 (
    .clk(clk), .rst(rst), .xlat_en(xlat_en),
    .req_valid(req_valid), .req_kind(req_kind), .req_vaddr(req_vaddr),
    .wr_en(wr_en), .wr_instr(wr_instr), .wr_region(wr_region),
    .wr_base(wr_base), .wr_attr(wr_attr),
    .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr), .rsp_page_size(rsp_page_size),
    .rsp_rwx(rsp_rwx), .rsp_cache(rsp_cache), .rsp_fault(rsp_fault), .rsp_cause(rsp_cause)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [4:0] exp_dec(input logic [3:0] c);
    case (c)
      4'd0:        return {3'b110, 2'd1};
      4'd1:        return {3'b111, 2'd1};
      4'd2:        return {3'b111, 2'd0};
      4'd3:        return {3'b001, 2'd2};
      4'd4, 4'd5:  return {3'b111, 2'd2};
      4'd14:       return {3'b110, 2'd3};
      default:     return {3'b000, 2'd0};
    endcase
  endfunction

  task automatic model_reset();
    for (int t = 0; t < 2; t++)
      for (int i = 0; i < 8; i++) begin
        mb[t][i] = 3'(i);
        ma[t][i] = 4'd2;
      end
  endtask

  task automatic model_write(input logic ti, input logic [2:0] r, input logic [2:0] b, input logic [3:0] a);
    ma[ti][r] = a;
    if (xlat_en) mb[ti][r] = b;
  endtask

  // compare current outputs with the model's answer for (kind, va)
  task automatic expect_rsp(input string tag, input logic [1:0] k, input logic [31:0] va);
    int t;
    logic [4:0] d;
    logic ok;
    logic [1:0] cz;
    t = (k == 2'd2) ? 1 : 0;
    d = exp_dec(ma[t][va[31:29]]);
    case (k)
      2'd1:    begin ok = d[3]; cz = 2'd2; end
      2'd2:    begin ok = d[2]; cz = 2'd3; end
      default: begin ok = d[4]; cz = 2'd1; end
    endcase
    chk({tag, " valid"}, 32'(rsp_valid), 32'd1);
    chk({tag, " paddr"}, rsp_paddr, {mb[t][va[31:29]], va[28:0]});
    chk({tag, " rwx"}, 32'(rsp_rwx), 32'(d[4:2]));
    chk({tag, " cache"}, 32'(rsp_cache), 32'(d[1:0]));
    chk({tag, " fault R4"}, 32'(rsp_fault), 32'(!ok));
    chk({tag, " cause R4"}, 32'(rsp_cause), ok ? 32'd0 : 32'(cz));
  endtask

  task automatic lookup(input string tag, input logic [1:0] k, input logic [31:0] va);
    @(negedge clk);
    req_valid = 1'b1; req_kind = k; req_vaddr = va;
    @(negedge clk);
    req_valid = 1'b0;
    expect_rsp(tag, k, va);
  endtask

  task automatic write_entry(input logic ti, input logic [2:0] r, input logic [2:0] b, input logic [3:0] a);
    @(negedge clk);
    wr_en = 1'b1; wr_instr = ti; wr_region = r; wr_base = b; wr_attr = a;
    @(negedge clk);
    wr_en = 1'b0;
    model_write(ti, r, b, a);
  endtask

  task automatic t_reset();
    chk("R5 reset valid", 32'(rsp_valid), 32'd0);
    chk("R5 reset fault", 32'(rsp_fault), 32'd0);
    chk("R7 page size", rsp_page_size, 32'h2000_0000);
  endtask

  task automatic t_identity();
    for (int i = 0; i < 8; i++) begin
      lookup("R5 identity data", 2'd0, {3'(i), 29'h0ABC_DE5} ^ 32'h0000_0F00);
      lookup("R5 identity instr", 2'd2, {3'(i), 29'h1234_567});
    end
  endtask

  task automatic t_codes();
    for (int c = 0; c < 16; c++) begin
      string tg;
      tg = (c <= 5 || c == 14) ? "R2 code" : "R3 code";
      write_entry(1'b0, 3'd3, 3'd0, 4'(c));
      write_entry(1'b1, 3'd3, 3'd0, 4'(c));
      lookup({tg, " read"}, 2'd0, 32'h6000_1234);
      lookup({tg, " write"}, 2'd1, 32'h7FFF_FFFC);
      lookup({tg, " fetch"}, 2'd2, 32'h6000_0040);
    end
    chk("R7 page size after traffic", rsp_page_size, 32'h2000_0000);
  endtask

  task automatic t_xlat();
    xlat_en = 1'b1;
    write_entry(1'b0, 3'd5, 3'd6, 4'd4);
    lookup("R1 relocated read", 2'd0, 32'hA123_4567);
    chk("R1 relocated paddr", rsp_paddr, 32'hC123_4567);
    xlat_en = 1'b0;
    write_entry(1'b0, 3'd5, 3'd1, 4'd0);
    lookup("R6 base kept", 2'd1, 32'hA000_0010);
    chk("R6 base kept paddr", rsp_paddr, 32'hC000_0010);
  endtask

  task automatic t_table_sel();
    write_entry(1'b1, 3'd0, 3'd0, 4'd15);
    lookup("R8 instr denied", 2'd2, 32'h0000_0100);
    lookup("R8 data untouched", 2'd0, 32'h0000_0100);
    write_entry(1'b0, 3'd1, 3'd0, 4'd3);
    lookup("R8 data exec-only read", 2'd0, 32'h2000_0000);
    lookup("R8 kind3 as read", 2'd3, 32'h2000_0000);
    lookup("R8 instr untouched", 2'd2, 32'h2000_0000);
  endtask

  task automatic t_collide();
    @(negedge clk);
    req_valid = 1'b1; req_kind = 2'd0; req_vaddr = 32'h8000_0020;
    wr_en = 1'b1; wr_instr = 1'b0; wr_region = 3'd4; wr_base = 3'd0; wr_attr = 4'd9;
    @(negedge clk);
    req_valid = 1'b0; wr_en = 1'b0;
    expect_rsp("R9 old entry", 2'd0, 32'h8000_0020);
    model_write(1'b0, 3'd4, 3'd0, 4'd9);
    @(negedge clk);
    chk("R9 valid one cycle", 32'(rsp_valid), 32'd0);
    lookup("R9 new entry", 2'd0, 32'h8000_0020);
    chk("R9 new entry faults", 32'(rsp_fault), 32'd1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_identity();
    t_codes();
    t_xlat();
    t_table_sel();
    t_collide();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule